// File: doc/BRIEF.md
# Parallel Bus Target Interface

This block is the board side of a 16-bit asynchronous parallel expansion bus. Every address, data, strobe, acknowledge and interrupt line on that bus is inverted on the wire: a logic 1 is carried as zero volts. The block turns the incoming wire levels into active-high values and passes the read and write strobes through a synchroniser. It then compares the low twelve address bits against a base address that is set by parameter, and decodes a small window of 16-bit registers.

On a matching write, the block captures the bus data into the addressed register. On a matching read, it enables its data drivers with the inverted register contents. In both cases it asks for the shared acknowledge line to be pulled low. Acknowledge and interrupt are open-drain lines, so the block never drives them high. It presents each of them as a pull-low enable, and a pull-up elsewhere restores the idle level. An internal event input sets the interrupt request. A write to a designated register offset clears it.

Top module: `pbus_target`

## Requirements
- R1: After reset, bus_ack_pull, bus_data_oe and bus_irq_pull are 0 and every register in reg_out is 0.
- R2: A write whose decoded address (bits 11:0 of ~bus_addr_n) falls in BASE_ADDR..BASE_ADDR+NUM_REGS-1 stores ~bus_data_n_in into register (address minus BASE_ADDR). Register k occupies reg_out[16k+15:16k], and the value is visible within 3 clocks of the write strobe falling on the wire.
- R3: During a matching read, bus_data_oe is 1 and bus_data_n_out equals the bitwise inverse of the addressed register, within 2 clocks of the read strobe falling.
- R4: bus_ack_pull is 1 within 2 clocks of a matching strobe falling, and returns to 0 within 2 clocks of the strobe rising.
- R5: Address bits 15:12 are ignored in decoding.
- R6: An address outside the window gives no acknowledge and no driver enable, and leaves every register unchanged.
- R7: When read and write strobes are both asserted, the block gives no acknowledge and no driver enable, and writes no register.
- R8: A one-clock pulse on irq_event sets bus_irq_pull, which stays at 1 until a matching write to offset IRQ_CLR_OFF (default 3) clears it.
- R9: bus_data_oe is never 1 during a write cycle.
- R10: One write strobe assertion performs one capture: data that changes while the strobe stays low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_n | input | 16 | Wire address, active low |
| bus_data_n_in | input | 16 | Wire data as sampled, active low |
| bus_data_n_out | output | 16 | Wire data level to drive on reads |
| bus_data_oe | output | 1 | Enable for the data drivers |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_ack_pull | output | 1 | 1 pulls the shared acknowledge line low |
| bus_irq_pull | output | 1 | 1 pulls the shared interrupt line low |
| irq_event | input | 1 | Internal event that raises the interrupt request |
| reg_out | output | 64 | All registers, active high, register k at bits 16k+15:16k |

## Verification
A strobe edge on the wire reaches the synchronised strobe after two clock edges. Acknowledge, driver enable and read data follow combinationally from it, so they are due after the second posedge. A captured write lands one edge later, on the third. The release of acknowledge is also due two edges after the strobe rises. Each task drives the bus at a negedge, counts exactly those posedges, and samples at the following negedge, so every check reads a settled value one half-period clear of any active edge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int BUS_W = 16;
    localparam int DEC_W = 12;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    typedef struct packed {
        logic            hit;
        logic            ack;
        logic            oe;
        logic            wr_pulse;
    } decode_t;

    function automatic logic [BUS_W-1:0] wire_to_logic(input logic [BUS_W-1:0] w);
        return ~w;
    endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_pkg::*;
#(
    parameter logic [DEC_W-1:0] BASE_ADDR = 12'h340,
    parameter int               OFF_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          stb,
    input  logic [DEC_W-1:0] addr,
    output decode_t          dec,
    output logic [OFF_W-1:0] off
);
    logic wr_prev;
    logic legal;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b0;
        else     wr_prev <= stb.wr;
    end

    always_comb begin
        legal        = stb.rd ^ stb.wr;
        dec.hit      = (addr[DEC_W-1:OFF_W] == BASE_ADDR[DEC_W-1:OFF_W]);
        dec.ack      = dec.hit && legal;
        dec.oe       = dec.hit && stb.rd && !stb.wr;
        dec.wr_pulse = dec.hit && stb.wr && !stb.rd && !wr_prev;
        off          = addr[OFF_W-1:0];
    end

    AST_NO_ACK_BOTH: assert property (@(posedge clk) disable iff (rst)
        (stb.rd && stb.wr) |-> (!dec.ack && !dec.oe && !dec.wr_pulse)); // R7
    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        dec.wr_pulse |=> !dec.wr_pulse); // R10
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
    import pbus_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int OFF_W       = 2,
    parameter int IRQ_CLR_OFF = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_pulse,
    input  logic [OFF_W-1:0]          off,
    input  logic [BUS_W-1:0]          wdata,
    input  logic                      irq_event,
    output logic [BUS_W-1:0]          rdata,
    output logic [NUM_REGS*BUS_W-1:0] reg_flat,
    output logic                      irq_pend
);
    logic [BUS_W-1:0] store [NUM_REGS];
    logic             clr_hit;

    assign clr_hit = wr_pulse && (off == OFF_W'(IRQ_CLR_OFF));

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                                 store[k] <= '0;
                else if (wr_pulse && off == OFF_W'(k))   store[k] <= wdata;
            end
            assign reg_flat[k*BUS_W +: BUS_W] = store[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            irq_pend <= 1'b0;
        else if (irq_event) irq_pend <= 1'b1;
        else if (clr_hit)   irq_pend <= 1'b0;
    end

    assign rdata = store[off];

    AST_REG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(reg_flat)); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && !clr_hit) |=> irq_pend); // R8
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        irq_event |=> irq_pend); // R8
endmodule

// File: rtl/pbus_target.sv
module pbus_target
    import pbus_pkg::*;
#(
    parameter logic [11:0] BASE_ADDR   = 12'h340,
    parameter int          NUM_REGS    = 4,
    parameter int          IRQ_CLR_OFF = 3,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [15:0]               bus_addr_n,
    input  logic [15:0]               bus_data_n_in,
    output logic [15:0]               bus_data_n_out,
    output logic                      bus_data_oe,
    input  logic                      bus_rd_n,
    input  logic                      bus_wr_n,
    output logic                      bus_ack_pull,
    output logic                      bus_irq_pull,
    input  logic                      irq_event,
    output logic [NUM_REGS*16-1:0]    reg_out
);
    localparam int OFF_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    strobe_t          stb_raw;
    strobe_t          stb;
    decode_t          dec;
    logic [OFF_W-1:0] off;
    logic [15:0]      addr_hi;
    logic [15:0]      wdata;
    logic [15:0]      rdata;
    logic             irq_pend;
    logic             unused_addr_top;

    assign addr_hi         = wire_to_logic(bus_addr_n);
    assign wdata           = wire_to_logic(bus_data_n_in);
    assign unused_addr_top = ^addr_hi[15:DEC_W];
    assign stb_raw.rd      = ~bus_rd_n;
    assign stb_raw.wr      = ~bus_wr_n;

    pbus_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (stb_raw),
        .q   (stb)
    );

    pbus_decode #(.BASE_ADDR(BASE_ADDR), .OFF_W(OFF_W)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .addr (addr_hi[DEC_W-1:0]),
        .dec  (dec),
        .off  (off)
    );

    pbus_regs #(.NUM_REGS(NUM_REGS), .OFF_W(OFF_W), .IRQ_CLR_OFF(IRQ_CLR_OFF)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_pulse  (dec.wr_pulse),
        .off       (off),
        .wdata     (wdata),
        .irq_event (irq_event),
        .rdata     (rdata),
        .reg_flat  (reg_out),
        .irq_pend  (irq_pend)
    );

    assign bus_ack_pull   = dec.ack;
    assign bus_data_oe    = dec.oe;
    assign bus_data_n_out = wire_to_logic(rdata);
    assign bus_irq_pull   = irq_pend;

    AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> bus_ack_pull); // R3
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!stb.rd && !stb.wr) |-> !bus_ack_pull); // R4
    AST_NO_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
        stb.wr |-> !bus_data_oe); // R9
endmodule

// File: tb/pbus_target_tb.sv
`timescale 1ns/1ps
module pbus_target_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr_n = 16'hFFFF;
    logic [15:0] bus_data_n_in = 16'hFFFF;
    logic [15:0] bus_data_n_out;
    logic        bus_data_oe;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic        bus_ack_pull;
    logic        bus_irq_pull;
    logic        irq_event = 1'b0;
    logic [63:0] reg_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [4];
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    pbus_target u_dut (
        .clk(clk), .rst(rst), .bus_addr_n(bus_addr_n), .bus_data_n_in(bus_data_n_in),
        .bus_data_n_out(bus_data_n_out), .bus_data_oe(bus_data_oe), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_ack_pull(bus_ack_pull), .bus_irq_pull(bus_irq_pull),
        .irq_event(irq_event), .reg_out(reg_out)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(reg_out == {model[3], model[2], model[1], model[0]}, req, reg_out,
              {model[3], model[2], model[1], model[0]});
    endtask

    function automatic logic in_window(input logic [15:0] a);
        return (a[11:0] >= 12'h340) && (a[11:0] <= 12'h343);
    endfunction

    task automatic t_write(input logic [15:0] a, input logic [15:0] d, input string req);
        logic hit = in_window(a);
        @(negedge clk);
        bus_addr_n = ~a; bus_data_n_in = ~d; bus_wr_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(bus_ack_pull == hit, {req, " R4 ack on write"}, bus_ack_pull, hit);
        check(bus_data_oe == 1'b0, {req, " R9 no drive on write"}, bus_data_oe, 0);
        @(posedge clk);
        @(negedge clk);
        if (hit) model[a[1:0]] = d;
        check_regs({req, " R2 capture"});
        bus_wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(bus_ack_pull == 1'b0, {req, " R4 ack release"}, bus_ack_pull, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input string req);
        logic hit = in_window(a);
        @(negedge clk);
        bus_addr_n = ~a; bus_rd_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(bus_data_oe == hit, {req, " R3 oe"}, bus_data_oe, hit);
        check(bus_ack_pull == hit, {req, " R4 ack on read"}, bus_ack_pull, hit);
        if (hit) check(~bus_data_n_out == model[a[1:0]], {req, " R3 data"},
                       ~bus_data_n_out, model[a[1:0]]);
        bus_rd_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!bus_ack_pull && !bus_data_oe, {req, " R4 release after read"},
              {bus_ack_pull, bus_data_oe}, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!bus_ack_pull && !bus_data_oe && !bus_irq_pull, "R1 outputs",
              {bus_ack_pull, bus_data_oe, bus_irq_pull}, 0);
        check(reg_out == 64'h0, "R1 registers", reg_out, 0);
    endtask

    task automatic t_both_strobes;
        @(negedge clk);
        bus_addr_n = ~16'h0341; bus_data_n_in = ~16'hDEAD;
        bus_rd_n = 1'b0; bus_wr_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!bus_ack_pull && !bus_data_oe, "R7 no ack or oe",
              {bus_ack_pull, bus_data_oe}, 0);
        check_regs("R7 no write");
        bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_regs("R7 no write after release");
    endtask

    task automatic t_held_write;
        @(negedge clk);
        bus_addr_n = ~16'h0342; bus_data_n_in = ~16'h1111; bus_wr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model[2] = 16'h1111;
        bus_data_n_in = ~16'h2222;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_regs("R10 single capture");
        bus_wr_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_irq;
        @(negedge clk);
        irq_event = 1'b1;
        @(negedge clk);
        irq_event = 1'b0;
        check(bus_irq_pull == 1'b1, "R8 set", bus_irq_pull, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(bus_irq_pull == 1'b1, "R8 held", bus_irq_pull, 1);
        t_write(16'h0340, 16'h0007, "R8 other offset");
        check(bus_irq_pull == 1'b1, "R8 not cleared by offset 0", bus_irq_pull, 1);
        t_write(16'h0343, 16'h00A5, "R8 clear write");
        check(bus_irq_pull == 1'b0, "R8 cleared by offset 3", bus_irq_pull, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write(16'h0340, 16'hA5C3, "R2 reg0");
        t_write(16'h0341, 16'h0001, "R2 reg1");
        t_write(16'h0343, 16'hFFFF, "R2 reg3");
        t_read(16'h0340, "R3 reg0");
        t_read(16'h0343, "R3 reg3");
        t_write(16'hF342, 16'h5A5A, "R5 upper bits set");
        t_read(16'hB341, "R5 read upper bits");
        t_write(16'h0344, 16'h9999, "R6 above window");
        t_write(16'h0240, 16'h8888, "R6 other base");
        t_read(16'h0344, "R6 read miss");
        t_both_strobes();
        t_held_write();
        t_read(16'h0342, "R10 readback");
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule